// File: doc/BRIEF.md
# Multi-Slot Card Clock Strobe Generator

This block makes the card clocks for a host controller that drives up to four card slots. A bank of four programmable dividers is shared by the slots. Each slot picks one divider through a 2-bit source field. Each slot also has its own enable bit and its own low-power bit. The outputs are single-cycle clock-enable strobes, one per slot, at the divided rate. They are not gated clocks. Logic downstream advances the card bus on each strobe.

Software writes the divider, source and enable words into shadow registers. Nothing reaches the running clocks until a command word is written that asks for a clock-only update. When that happens, the shadow words are copied into the live set in one cycle, and a busy flag shows the update in flight. A divider only picks up a new value at the end of a full output period, so a change never produces a shortened period.

Top module: `sdclk_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, every card strobe is low and the update-busy flag is low.
- R2: Writes to the divider word (address 0), source word (address 1) or enable word (address 2) change no output until an update command is accepted.
- R3: A command word (address 3) starts an update only if bit 31 (start), bit 21 (clock-only) and bit 13 (wait for previous data) are all set. A command missing any of them is ignored, and the busy flag stays low.
- R4: After an accepted command, the busy flag is high for exactly two cycles: the copy cycle and one cycle after it. The live settings change only at the copy.
- R5: A divider value of 0 produces a strobe on every clock cycle.
- R6: A divider value N greater than 0 produces one strobe every 2×N clock cycles. For example, N=60 gives one strobe per 120 cycles, which is 200 kHz from a 24 MHz input.
- R7: Card i takes its strobes from the divider named by bits 2i+1:2i of the source word.
- R8: Card i strobes only while bit i of the live enable word is set.
- R9: If bit 16+i of the live enable word (low power) is set and card i is idle (its card_active input is low), card i gives no strobes. While the card is active, its strobes run normally.
- R10: A new divider value takes effect only at the end of a full output period. Every interval between strobes equals either the old period or the new one.
- R11: Divider k is set from bits 8k+7:8k of the divider word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 divider, 1 source, 2 enable, 3 command |
| wr_data | input | 32 | Register write data |
| card_active | input | 4 | Per-card flag: a command or data transfer is in progress |
| card_clk_en | output | 4 | Per-card single-cycle clock strobe |
| upd_busy | output | 1 | Update in progress (start bit still set) |

## Verification
The bench goes after five kinds of error:
- A design that leaked shadow writes straight into the clocks would strobe before any command.
- One that decoded the command from the start bit alone would raise busy on an incomplete word.
- Off-by-one errors in the divider would show as intervals of 2N±1, or of N instead of 2N, when intervals are measured for N of 0, 3, 5 and 60.
- A divider reloaded mid-period would produce an interval that matches neither the old period nor the new one when a value changes while its card is running.
- The low-power bit is toggled against the card-active input to catch gating that ignores activity, or that silences active cards.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int REG_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    ADDR_DIV = 2'd0,
    ADDR_SRC = 2'd1,
    ADDR_ENA = 2'd2,
    ADDR_CMD = 2'd3
  } reg_addr_e;

  // bit positions inside the command word that request a clock-only update
  localparam int CMD_START_BIT   = 31;
  localparam int CMD_CLKONLY_BIT = 21;
  localparam int CMD_WAITPRV_BIT = 13;

  // low-power bits start here in the enable word
  localparam int LP_LSB = 16;

  typedef enum logic [1:0] {
    UPD_IDLE = 2'd0,
    UPD_COPY = 2'd1,
    UPD_DONE = 2'd2
  } upd_state_e;
endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
  import sdclk_pkg::*;
#(
  parameter int NUM_CARDS = 4,
  parameter int NUM_DIVS  = 4,
  parameter int DIV_W     = 8,
  localparam int SRC_W    = (NUM_DIVS > 1) ? $clog2(NUM_DIVS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [REG_W-1:0]            wr_data,
  output logic [NUM_DIVS*DIV_W-1:0]   live_div,
  output logic [NUM_CARDS*SRC_W-1:0]  live_src,
  output logic [NUM_CARDS-1:0]        live_en,
  output logic [NUM_CARDS-1:0]        live_lp,
  output logic                        busy
);
  logic [NUM_DIVS*DIV_W-1:0]  sh_div;
  logic [NUM_CARDS*SRC_W-1:0] sh_src;
  logic [NUM_CARDS-1:0]       sh_en;
  logic [NUM_CARDS-1:0]       sh_lp;
  upd_state_e                 state;
  logic                       cmd_ok;

  assign cmd_ok = wr_en && (wr_addr == ADDR_CMD) && wr_data[CMD_START_BIT]
                  && wr_data[CMD_CLKONLY_BIT] && wr_data[CMD_WAITPRV_BIT];

  // shadow set: written at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_div <= '0;
      sh_src <= '0;
      sh_en  <= '0;
      sh_lp  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_DIV: sh_div <= wr_data[NUM_DIVS*DIV_W-1:0];
        ADDR_SRC: sh_src <= wr_data[NUM_CARDS*SRC_W-1:0];
        ADDR_ENA: begin
          sh_en <= wr_data[NUM_CARDS-1:0];
          sh_lp <= wr_data[LP_LSB +: NUM_CARDS];
        end
        default: ;
      endcase
    end
  end

  // update handshake and live set
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= UPD_IDLE;
      live_div <= '0;
      live_src <= '0;
      live_en  <= '0;
      live_lp  <= '0;
    end else begin
      case (state)
        UPD_IDLE: if (cmd_ok) state <= UPD_COPY;
        UPD_COPY: begin
          live_div <= sh_div;
          live_src <= sh_src;
          live_en  <= sh_en;
          live_lp  <= sh_lp;
          state    <= UPD_DONE;
        end
        default: state <= UPD_IDLE;
      endcase
    end
  end

  assign busy = (state != UPD_IDLE);
endmodule

// File: rtl/sdclk_div.sv
module sdclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cur;
  logic [DIV_W-1:0] cnt;
  logic             phase;
  logic             half_wrap;
  logic             full_wrap;

  assign half_wrap = (cur != '0) && (cnt == cur - 1'b1);
  assign full_wrap = (cur == '0) || (half_wrap && phase);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= '0;
      cnt   <= '0;
      phase <= 1'b0;
      tick  <= 1'b0;
    end else begin
      tick <= full_wrap;
      if (full_wrap) begin
        cur   <= div_val;   // reload only at end of a full period
        cnt   <= '0;
        phase <= 1'b0;
      end else if (half_wrap) begin
        cnt   <= '0;
        phase <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate #(
  parameter int NUM_CARDS = 4,
  parameter int NUM_DIVS  = 4,
  localparam int SRC_W    = (NUM_DIVS > 1) ? $clog2(NUM_DIVS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_DIVS-1:0]        ticks,
  input  logic [NUM_CARDS*SRC_W-1:0] src,
  input  logic [NUM_CARDS-1:0]       en,
  input  logic [NUM_CARDS-1:0]       lp,
  input  logic [NUM_CARDS-1:0]       active,
  output logic [NUM_CARDS-1:0]       strobe
);
  for (genvar c = 0; c < NUM_CARDS; c++) begin : g_card
    logic [SRC_W-1:0] sel;
    logic             pick;
    logic             allow;
    assign sel   = src[c*SRC_W +: SRC_W];
    assign pick  = (int'(sel) < NUM_DIVS) ? ticks[sel] : 1'b0;
    assign allow = en[c] && !(lp[c] && !active[c]);
    always_ff @(posedge clk) begin
      if (rst) strobe[c] <= 1'b0;
      else     strobe[c] <= pick && allow;
    end
  end
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int NUM_CARDS = 4,
  parameter int NUM_DIVS  = 4,
  parameter int DIV_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [NUM_CARDS-1:0] card_active,
  output logic [NUM_CARDS-1:0] card_clk_en,
  output logic                 upd_busy
);
  localparam int SRC_W = (NUM_DIVS > 1) ? $clog2(NUM_DIVS) : 1;

  logic [NUM_DIVS*DIV_W-1:0]  live_div;
  logic [NUM_CARDS*SRC_W-1:0] live_src;
  logic [NUM_CARDS-1:0]       live_en;
  logic [NUM_CARDS-1:0]       live_lp;
  logic [NUM_DIVS-1:0]        ticks;

  sdclk_regs #(.NUM_CARDS(NUM_CARDS), .NUM_DIVS(NUM_DIVS), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .live_div(live_div), .live_src(live_src), .live_en(live_en),
    .live_lp(live_lp), .busy(upd_busy)
  );

  for (genvar d = 0; d < NUM_DIVS; d++) begin : g_div
    sdclk_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst(rst),
      .div_val(live_div[d*DIV_W +: DIV_W]),
      .tick(ticks[d])
    );
  end

  sdclk_gate #(.NUM_CARDS(NUM_CARDS), .NUM_DIVS(NUM_DIVS)) u_gate (
    .clk(clk), .rst(rst), .ticks(ticks), .src(live_src), .en(live_en),
    .lp(live_lp), .active(card_active), .strobe(card_clk_en)
  );
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
  parameter int NUM_CARDS = 4,
  parameter int NUM_DIVS  = 4,
  parameter int DIV_W     = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_CARDS-1:0]      card_clk_en,
  input logic [NUM_CARDS-1:0]      card_active,
  input logic                      upd_busy,
  input logic [NUM_CARDS-1:0]      live_en,
  input logic [NUM_CARDS-1:0]      live_lp,
  input logic [NUM_DIVS*DIV_W-1:0] live_div
);
  // R4: busy lasts exactly two cycles
  a_r4_busy_two: assert property (@(posedge clk) disable iff (rst)
    $rose(upd_busy) |=> upd_busy);
  a_r4_busy_ends: assert property (@(posedge clk) disable iff (rst)
    (upd_busy && $past(upd_busy)) |=> !upd_busy);
  // R3: live settings move only during an update
  a_r3_live_hold: assert property (@(posedge clk) disable iff (rst)
    !upd_busy |=> ($stable(live_div) && $stable(live_en) && $stable(live_lp)));
  // R8: a disabled card never strobes
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (card_clk_en & ~$past(live_en)) == '0);
  // R9: an idle card in low-power mode never strobes
  a_r9_lp_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (card_clk_en & $past(live_lp & ~card_active)) == '0);
endmodule

bind sdclk_gen sdclk_gen_chk #(.NUM_CARDS(NUM_CARDS), .NUM_DIVS(NUM_DIVS), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .card_clk_en(card_clk_en), .card_active(card_active),
  .upd_busy(upd_busy), .live_en(live_en), .live_lp(live_lp), .live_div(live_div)
);

// File: tb/sdclk_gen_tb.sv
module sdclk_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [3:0]  card_active = 4'd0;
  logic [3:0]  card_clk_en;
  logic        upd_busy;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [31:0] CMD_OK = (32'd1 << 31) | (32'd1 << 21) | (32'd1 << 13);

  always #5 clk = ~clk;

  sdclk_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .card_active(card_active), .card_clk_en(card_clk_en), .upd_busy(upd_busy)
  );

  // ---------------- behavioural reference model ----------------
  int   s_div[4], s_src[4], l_div[4], l_src[4];
  bit   s_en[4], s_lp[4], l_en[4], l_lp[4];
  int   rem[4], cur[4];
  bit   tk[4];
  int   st;
  logic [3:0] m_out;
  bit   m_busy;

  always @(posedge clk) begin
    bit   ntk[4];
    logic [3:0] nout;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        s_div[i] = 0; s_src[i] = 0; l_div[i] = 0; l_src[i] = 0;
        s_en[i] = 0; s_lp[i] = 0; l_en[i] = 0; l_lp[i] = 0;
        rem[i] = 0; cur[i] = 0; tk[i] = 0;
      end
      st = 0; m_out = 4'd0; m_busy = 0;
    end else begin
      for (int c = 0; c < 4; c++)
        nout[c] = tk[l_src[c]] && l_en[c] && !(l_lp[c] && !card_active[c]);
      for (int d = 0; d < 4; d++) begin
        ntk[d] = (rem[d] == 0);
        if (ntk[d]) begin
          cur[d] = l_div[d];
          rem[d] = ((cur[d] == 0) ? 1 : 2 * cur[d]) - 1;
        end else rem[d] = rem[d] - 1;
      end
      if (st == 1) begin
        for (int i = 0; i < 4; i++) begin
          l_div[i] = s_div[i]; l_src[i] = s_src[i]; l_en[i] = s_en[i]; l_lp[i] = s_lp[i];
        end
        st = 2;
      end else if (st == 2) st = 0;
      else if (wr_en && wr_addr == 2'd3 && wr_data[31] && wr_data[21] && wr_data[13]) st = 1;
      if (wr_en) begin
        for (int i = 0; i < 4; i++) begin
          if (wr_addr == 2'd0) s_div[i] = int'(wr_data[8*i +: 8]);
          if (wr_addr == 2'd1) s_src[i] = int'(wr_data[2*i +: 2]);
          if (wr_addr == 2'd2) begin s_en[i] = wr_data[i]; s_lp[i] = wr_data[16+i]; end
        end
      end
      for (int d = 0; d < 4; d++) tk[d] = ntk[d];
      m_out = nout;
      m_busy = (st != 0);
    end
  end

  // per-cycle compare against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (card_clk_en !== m_out) begin
        failures++;
        $display("FAIL R6 strobe compare (R5 R7 R8 R9 R10 R11): actual %b expected %b", card_clk_en, m_out);
      end
      checks++;
      if (upd_busy !== m_busy) begin
        failures++;
        $display("FAIL R4 busy compare: actual %b expected %b", upd_busy, m_busy);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic commit();
    wr(2'd3, CMD_OK);
    repeat (3) @(negedge clk);
  endtask

  task automatic count_strobes(input int c, input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (card_clk_en[c]) cnt++;
    end
  endtask

  task automatic interval(input int c, output int n);
    int guard = 0;
    while (!card_clk_en[c] && guard < 1000) begin @(negedge clk); guard++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!card_clk_en[c] && n < 1000);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int n;
    int cnt;
    repeat (3) @(negedge clk);
    check("R1 strobes in reset", int'(card_clk_en), 0);
    check("R1 busy in reset", int'(upd_busy), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 strobes after reset", int'(card_clk_en), 0);

    // R11 div0=0 div1=3 div2=60 div3=5 ; R7 card0->2 card1->0 card2->1 card3->3
    wr(2'd0, {8'd5, 8'd60, 8'd3, 8'd0});
    wr(2'd1, 32'h000000D2);
    wr(2'd2, 32'h0000000F);
    count_strobes(0, 20, cnt);
    check("R2 no strobe before commit", cnt, 0);

    wr(2'd3, CMD_OK & ~(32'd1 << 21));
    check("R3 busy after incomplete cmd", int'(upd_busy), 0);
    wr(2'd3, CMD_OK & ~(32'd1 << 13));
    check("R3 busy after cmd without wait bit", int'(upd_busy), 0);
    count_strobes(1, 10, cnt);
    check("R3 no strobe after ignored cmd", cnt, 0);

    wr(2'd3, CMD_OK);
    check("R4 busy copy cycle", int'(upd_busy), 1);
    @(negedge clk);
    check("R4 busy second cycle", int'(upd_busy), 1);
    @(negedge clk);
    check("R4 busy cleared", int'(upd_busy), 0);

    interval(1, n); check("R5 full rate interval", n, 1);
    interval(0, n); check("R6 N=60 interval", n, 120);
    interval(2, n); check("R7 card2 via divider1 interval", n, 6);
    interval(3, n); check("R11 divider3 field interval", n, 10);

    // R10: divider3 from 5 to 2 while running
    wr(2'd0, {8'd2, 8'd60, 8'd3, 8'd0});
    wr(2'd3, CMD_OK);
    for (int k = 0; k < 6; k++) begin
      interval(3, n);
      checks++;
      if (n != 10 && n != 4) begin
        failures++;
        $display("FAIL R10 interval: actual %0d expected 10 or 4", n);
      end
    end
    check("R10 settled interval", n, 4);

    // R8: disable card2
    wr(2'd2, 32'h0000000B);
    commit();
    count_strobes(2, 30, cnt);
    check("R8 disabled card2 strobes", cnt, 0);
    count_strobes(3, 30, cnt);
    checks++;
    if (cnt == 0) begin failures++; $display("FAIL R8 card3 strobes: actual 0 expected >0"); end

    // R9: low power on card3
    wr(2'd2, 32'h0008000B);
    commit();
    count_strobes(3, 40, cnt);
    check("R9 idle low-power card3 strobes", cnt, 0);
    @(negedge clk); card_active[3] = 1'b1;
    count_strobes(3, 40, cnt);
    check("R9 active low-power card3 strobes", cnt, 10);
    card_active[3] = 1'b0;
    count_strobes(1, 8, cnt);
    check("R5 card1 unaffected", cnt, 8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule